// File: doc/BRIEF.md
# HDLC Receive Short-Frame Classifier

This block sits between the byte deframer of an HDLC receiver and its receive buffer. The deframer hands over each complete received byte with a strobe. At the closing flag it gives a one-cycle frame-end pulse carrying the frame's length in bits, opening and closing flags excluded. The block holds the first bytes of every frame in a small staging store until it knows the length. It then decides whether the frame is discarded, delivered as a short frame with a status tag on its final character, or delivered as normal data. The decision uses the bit count, a 2-bit address-field mode and a CRC-control bit.

Once five bytes (40 bits) of a frame are held, the frame can no longer be short. The block then streams it to the buffer, always keeping the newest byte back so that the final character can be marked. A short-frame flag and an end-of-message flag are sticky, each cleared by its own write-one pulse. The interrupt request is the short-frame flag gated by an enable. Flag detection, bit de-stuffing and CRC computation belong to the deframer.

The controller states are:
- GATHER: idle or collecting; the frame is still undecided.
- PASS: streaming a long frame.
- DRAIN_NORM: emptying the staging store for a normal frame.
- DRAIN_SHRT: emptying it for a short frame.
- DISCARD: one-cycle flush of a dropped frame.

The transitions are:
- GATHER to PASS when the fifth byte is stored.
- GATHER to DISCARD, DRAIN_SHRT or DRAIN_NORM at frame end, according to the length class. When nothing is staged, GATHER stays in GATHER.
- PASS to DRAIN_NORM at frame end.
- Both drain states to GATHER after the final character.
- DISCARD to GATHER.

Interface rules:
- frame_end arrives at least one cycle after the frame's last byte strobe, never in the same cycle.
- The next frame's first byte comes at least 8 cycles after frame_end.
- addr_mode and crc_ctl are stable while frame_end is high.

Top module: `rxframe_len_gate`

## Requirements
- R1: A frame of 0 to 8 bits writes nothing to the buffer and sets no flag, in every mode and CRC setting.
- R2: A frame of 9 to 23 bits is short when crc_ctl is 0 (partial data written, tagged). When crc_ctl is 1 it writes nothing and sets no flag.
- R3: A frame of 24 to 31 bits is short in every mode and CRC setting.
- R4: addr_mode encodes 00 no-check, 01 single address 1, 10 single address 2, 11 dual address. A frame of 32 to 39 bits is normal in modes 00 and 01, and short in modes 10 and 11 for either CRC setting.
- R5: A frame of 40 bits or more is delivered as normal data: every byte in arrival order, only the final one with wr_last=1, none with wr_short=1. This also holds for frames far longer than the staging store.
- R6: A delivered frame (short or normal) writes all its received complete bytes in arrival order, at most one per cycle. wr_last=1 marks only its final character. wr_short=1 appears only on the final character of a short frame.
- R7: shrt_flag goes to 1 in the cycle after the short-tagged final write. eom_flag is 1 in that same cycle. eom_flag is also set after the final character of a normal frame.
- R8: irq equals shrt_flag AND shrt_ie, and follows shrt_ie while shrt_flag is held.
- R9: A frame classed short that delivered no byte sets neither shrt_flag nor eom_flag.
- R10: A clr_shrt pulse clears only shrt_flag. A clr_eom pulse clears only eom_flag.
- R11: After reset wr_en, shrt_flag, eom_flag and irq are 0.
- R12: The cycle after a final-character write carries no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A received complete byte is on byte_data |
| byte_data | input | DATA_W | Received byte |
| frame_end | input | 1 | One-cycle pulse at the closing flag |
| frame_bits | input | BITS_W | Frame length in bits, flags excluded, valid with frame_end |
| addr_mode | input | 2 | Address-field mode (encoding in R4) |
| crc_ctl | input | 1 | CRC-control bit (effect in R2) |
| shrt_ie | input | 1 | Short-frame interrupt enable |
| clr_shrt | input | 1 | Write-one pulse clearing shrt_flag |
| clr_eom | input | 1 | Write-one pulse clearing eom_flag |
| wr_en | output | 1 | Buffer write strobe |
| wr_data | output | DATA_W | Character written to the buffer |
| wr_last | output | 1 | Written character is the frame's final one |
| wr_short | output | 1 | Short-frame status tag on the written character |
| shrt_flag | output | 1 | Sticky short-frame flag |
| eom_flag | output | 1 | Sticky end-of-message flag |
| irq | output | 1 | Interrupt request |

## Verification
Two cases are the hardest to reach from the ports. The first is a frame whose bit count says short while no byte was ever strobed; the bench creates it by pulsing frame_end with a 12-bit length and no preceding bytes, and expects silence on both flags. The second is the hand-over from staging to streaming: the bench sends frames of exactly five, six and twenty bytes, so that the fifth byte switches to PASS and the retained final byte is drained with wr_last. Boundary lengths 8, 9, 23, 24, 31, 32, 39 and 40 bits are each sent under the modes and CRC settings whose outcome they separate.

// File: rtl/rxframe_len_pkg.sv
package rxframe_len_pkg;

    typedef enum logic [1:0] {
        CLS_DROP   = 2'd0,
        CLS_SHORT  = 2'd1,
        CLS_NORMAL = 2'd2
    } len_cls_e;

    typedef enum logic [2:0] {
        S_GATHER     = 3'd0,
        S_PASS       = 3'd1,
        S_DRAIN_NORM = 3'd2,
        S_DRAIN_SHRT = 3'd3,
        S_DISCARD    = 3'd4
    } rx_state_e;

    typedef enum logic [1:0] {
        AM_NOCHK = 2'b00,
        AM_SA1   = 2'b01,
        AM_SA2   = 2'b10,
        AM_DUAL  = 2'b11
    } addr_mode_e;

endpackage

// File: rtl/rxframe_len_class.sv
module rxframe_len_class
    import rxframe_len_pkg::*;
#(
    parameter int BITS_W   = 16,
    parameter int TINY_MAX = 8,
    parameter int CRC_LIM  = 24,
    parameter int MID_LIM  = 32,
    parameter int LONG_LIM = 40
) (
    input  logic [BITS_W-1:0] frame_bits,
    input  logic [1:0]        addr_mode,
    input  logic              crc_ctl,
    output len_cls_e          cls
);

    always_comb begin
        if (frame_bits <= BITS_W'(TINY_MAX)) begin
            cls = CLS_DROP;
        end else if (frame_bits < BITS_W'(CRC_LIM)) begin
            cls = crc_ctl ? CLS_DROP : CLS_SHORT;
        end else if (frame_bits < BITS_W'(MID_LIM)) begin
            cls = CLS_SHORT;
        end else if (frame_bits < BITS_W'(LONG_LIM)) begin
            unique case (addr_mode_e'(addr_mode))
                AM_NOCHK, AM_SA1: cls = CLS_NORMAL;
                AM_SA2, AM_DUAL:  cls = CLS_SHORT;
                default:          cls = CLS_NORMAL;
            endcase
        end else begin
            cls = CLS_NORMAL;
        end
    end

endmodule

// File: rtl/rxframe_stage.sv
module rxframe_stage #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    input  logic                       flush,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] cnt
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign pop_ok  = pop && (cnt_q != '0);
    assign push_ok = push && ((cnt_q != CW'(DEPTH)) || pop_ok);

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wp_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= bump(wp_q);
            if (pop_ok)  rp_q <= bump(rp_q);
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    assign head = mem[rp_q];
    assign cnt  = cnt_q;

endmodule

// File: rtl/rxframe_flags.sv
module rxframe_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_shrt,
    input  logic set_eom,
    input  logic clr_shrt,
    input  logic clr_eom,
    input  logic shrt_ie,
    output logic shrt_flag,
    output logic eom_flag,
    output logic irq
);

    logic shrt_q, eom_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shrt_q <= 1'b0;
            eom_q  <= 1'b0;
        end else begin
            if (set_shrt)      shrt_q <= 1'b1;
            else if (clr_shrt) shrt_q <= 1'b0;
            if (set_eom)       eom_q  <= 1'b1;
            else if (clr_eom)  eom_q  <= 1'b0;
        end
    end

    assign shrt_flag = shrt_q;
    assign eom_flag  = eom_q;
    assign irq       = shrt_q && shrt_ie;

endmodule

// File: rtl/rxframe_len_gate.sv
module rxframe_len_gate
    import rxframe_len_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int BITS_W      = 16,
    parameter int STAGE_DEPTH = 8,
    parameter int TINY_MAX    = 8,
    parameter int CRC_LIM     = 24,
    parameter int MID_LIM     = 32,
    parameter int LONG_LIM    = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              frame_end,
    input  logic [BITS_W-1:0] frame_bits,
    input  logic [1:0]        addr_mode,
    input  logic              crc_ctl,
    input  logic              shrt_ie,
    input  logic              clr_shrt,
    input  logic              clr_eom,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last,
    output logic              wr_short,
    output logic              shrt_flag,
    output logic              eom_flag,
    output logic              irq
);

    localparam int CW        = $clog2(STAGE_DEPTH + 1);
    localparam int PASS_FILL = LONG_LIM / DATA_W;

    rx_state_e         state_q, state_d;
    len_cls_e          cls;
    logic [CW-1:0]     stage_cnt;
    logic [DATA_W-1:0] stage_head;
    logic              st_push, st_pop, st_flush;
    logic              last_char;

    rxframe_len_class #(
        .BITS_W  (BITS_W),
        .TINY_MAX(TINY_MAX),
        .CRC_LIM (CRC_LIM),
        .MID_LIM (MID_LIM),
        .LONG_LIM(LONG_LIM)
    ) u_class (
        .frame_bits(frame_bits),
        .addr_mode (addr_mode),
        .crc_ctl   (crc_ctl),
        .cls       (cls)
    );

    rxframe_stage #(
        .W    (DATA_W),
        .DEPTH(STAGE_DEPTH)
    ) u_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .push (st_push),
        .din  (byte_data),
        .pop  (st_pop),
        .flush(st_flush),
        .head (stage_head),
        .cnt  (stage_cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_GATHER;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_GATHER: begin
                if (frame_end) begin
                    unique case (cls)
                        CLS_DROP:   state_d = S_DISCARD;
                        CLS_SHORT:  state_d = (stage_cnt == '0) ? S_GATHER : S_DRAIN_SHRT;
                        CLS_NORMAL: state_d = (stage_cnt == '0) ? S_GATHER : S_DRAIN_NORM;
                        default:    state_d = S_DISCARD;
                    endcase
                end else if (byte_vld && stage_cnt == CW'(PASS_FILL - 1)) begin
                    state_d = S_PASS;
                end
            end
            S_PASS: begin
                if (frame_end) state_d = S_DRAIN_NORM;
            end
            S_DRAIN_NORM, S_DRAIN_SHRT: begin
                if (stage_cnt <= CW'(1)) state_d = S_GATHER;
            end
            S_DISCARD: state_d = S_GATHER;
            default:   state_d = S_GATHER;
        endcase
    end

    // Outputs
    always_comb begin
        st_push   = 1'b0;
        st_pop    = 1'b0;
        st_flush  = 1'b0;
        last_char = 1'b0;
        wr_short  = 1'b0;
        unique case (state_q)
            S_GATHER: begin
                st_push = byte_vld;
            end
            S_PASS: begin
                st_push = byte_vld;
                st_pop  = (stage_cnt > CW'(1));
            end
            S_DRAIN_NORM: begin
                st_pop    = (stage_cnt != '0);
                last_char = (stage_cnt == CW'(1));
            end
            S_DRAIN_SHRT: begin
                st_pop    = (stage_cnt != '0);
                last_char = (stage_cnt == CW'(1));
                wr_short  = (stage_cnt == CW'(1));
            end
            S_DISCARD: begin
                st_flush = 1'b1;
            end
            default: begin
                st_flush = 1'b1;
            end
        endcase
    end

    assign wr_en   = st_pop;
    assign wr_data = stage_head;
    assign wr_last = last_char;

    rxframe_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_shrt (wr_en && wr_short),
        .set_eom  (wr_en && wr_last),
        .clr_shrt (clr_shrt),
        .clr_eom  (clr_eom),
        .shrt_ie  (shrt_ie),
        .shrt_flag(shrt_flag),
        .eom_flag (eom_flag),
        .irq      (irq)
    );

endmodule

// File: rtl/rxframe_len_chk.sv
module rxframe_len_chk
    import rxframe_len_pkg::*;
#(
    parameter int BITS_W      = 16,
    parameter int STAGE_DEPTH = 8,
    parameter int TINY_MAX    = 8,
    parameter int CRC_LIM     = 24
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             frame_end,
    input logic [BITS_W-1:0]                frame_bits,
    input logic                             crc_ctl,
    input logic                             shrt_ie,
    input logic                             wr_en,
    input logic                             wr_last,
    input logic                             wr_short,
    input logic                             shrt_flag,
    input logic                             eom_flag,
    input logic                             irq,
    input logic [$clog2(STAGE_DEPTH+1)-1:0] stage_cnt,
    input rx_state_e                        state
);

    p_tiny_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && state == S_GATHER && frame_bits <= BITS_W'(TINY_MAX)) |=> !wr_en);

    p_crc_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && state == S_GATHER && crc_ctl && frame_bits < BITS_W'(CRC_LIM)) |=> !wr_en);

    p_stage_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stage_cnt <= ($bits(stage_cnt))'(STAGE_DEPTH));

    p_tag_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_short |-> (wr_en && wr_last));

    p_eom_with_shrt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shrt_flag) |-> eom_flag);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (shrt_ie && shrt_flag));

    p_shrt_needs_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shrt_flag) |-> $past(wr_en && wr_short));

    p_gap_after_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_last) |=> !wr_en);

endmodule

bind rxframe_len_gate rxframe_len_chk #(
    .BITS_W     (BITS_W),
    .STAGE_DEPTH(STAGE_DEPTH),
    .TINY_MAX   (TINY_MAX),
    .CRC_LIM    (CRC_LIM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .frame_bits(frame_bits),
    .crc_ctl   (crc_ctl),
    .shrt_ie   (shrt_ie),
    .wr_en     (wr_en),
    .wr_last   (wr_last),
    .wr_short  (wr_short),
    .shrt_flag (shrt_flag),
    .eom_flag  (eom_flag),
    .irq       (irq),
    .stage_cnt (stage_cnt),
    .state     (state_q)
);

// File: tb/rxframe_len_gate_tb.sv
module rxframe_len_gate_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       frame_end = 1'b0;
    logic [15:0] frame_bits = '0;
    logic [1:0] addr_mode = 2'b00;
    logic       crc_ctl = 1'b0;
    logic       shrt_ie = 1'b1;
    logic       clr_shrt = 1'b0;
    logic       clr_eom = 1'b0;
    logic       wr_en, wr_last, wr_short, shrt_flag, eom_flag, irq;
    logic [7:0] wr_data;

    always #5 clk = ~clk;

    rxframe_len_gate u_dut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .frame_end(frame_end), .frame_bits(frame_bits), .addr_mode(addr_mode),
        .crc_ctl(crc_ctl), .shrt_ie(shrt_ie), .clr_shrt(clr_shrt), .clr_eom(clr_eom),
        .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .wr_short(wr_short),
        .shrt_flag(shrt_flag), .eom_flag(eom_flag), .irq(irq)
    );

    typedef struct packed {
        logic [7:0] d;
        logic       last;
        logic       shrt;
    } exp_t;

    exp_t  expq[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R11";

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // 0 drop, 1 short, 2 normal
    function automatic int model_cls(input int bits, input logic [1:0] mode, input bit crc);
        if (bits <= 8) return 0;
        if (bits < 24) return crc ? 0 : 1;
        if (bits < 32) return 1;
        if (bits < 40) return (mode == 2'b10 || mode == 2'b11) ? 1 : 2;
        return 2;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && wr_en === 1'b1) begin
            if (expq.size() == 0) begin
                check(cur_req, 1, 0, "unexpected buffer write");
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(cur_req, int'(wr_data), int'(e.d), "wr_data");
                check("R6", int'(wr_last), int'(e.last), "wr_last");
                check("R6", int'(wr_short), int'(e.shrt), "wr_short");
            end
        end
    end

    task automatic clear_flags();
        @(posedge clk); #1;
        clr_shrt = 1'b1;
        clr_eom  = 1'b1;
        @(posedge clk); #1;
        clr_shrt = 1'b0;
        clr_eom  = 1'b0;
    endtask

    task automatic run_frame(input string req, input int nbytes, input int bits,
                             input logic [1:0] mode, input bit crc, input logic [7:0] seed,
                             input bit do_clear);
        int c;
        bit exp_shrt, exp_eom;
        cur_req = req;
        c = model_cls(bits, mode, crc);
        exp_shrt = (c == 1) && (nbytes > 0);
        exp_eom  = (c != 0) && (nbytes > 0);
        if (c != 0) begin
            for (int i = 0; i < nbytes; i++) begin
                exp_t e;
                e.d    = seed + 8'(i);
                e.last = (i == nbytes - 1);
                e.shrt = (c == 1) && (i == nbytes - 1);
                expq.push_back(e);
            end
        end
        @(posedge clk); #1;
        addr_mode = mode;
        crc_ctl   = crc;
        for (int i = 0; i < nbytes; i++) begin
            @(posedge clk); #1;
            byte_vld  = 1'b1;
            byte_data = seed + 8'(i);
        end
        @(posedge clk); #1;
        byte_vld   = 1'b0;
        frame_end  = 1'b1;
        frame_bits = 16'(bits);
        @(posedge clk); #1;
        frame_end  = 1'b0;
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(req, expq.size(), 0, "characters still expected");
        check(req, int'(shrt_flag), int'(exp_shrt), "shrt_flag");
        check("R7", int'(eom_flag), int'(exp_eom), "eom_flag");
        check("R8", int'(irq), int'(exp_shrt && shrt_ie), "irq");
        if (do_clear) clear_flags();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check("R11", int'(wr_en), 0, "wr_en in reset");
        check("R11", int'(shrt_flag), 0, "shrt_flag in reset");
        check("R11", int'(eom_flag), 0, "eom_flag in reset");
        check("R11", int'(irq), 0, "irq in reset");
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1 tiny frames, every mode
        for (int m = 0; m < 4; m++) begin
            run_frame("R1", 1, 8, 2'(m), 1'b0, 8'h10, 1'b1);
        end
        run_frame("R1", 0, 0, 2'b11, 1'b1, 8'h11, 1'b1);

        // R2 9..23 bits
        run_frame("R2", 1, 9, 2'b00, 1'b0, 8'h20, 1'b1);
        run_frame("R2", 2, 16, 2'b01, 1'b0, 8'h24, 1'b1);
        run_frame("R2", 2, 23, 2'b11, 1'b0, 8'h28, 1'b1);
        run_frame("R2", 2, 16, 2'b00, 1'b1, 8'h2C, 1'b1);
        run_frame("R2", 2, 23, 2'b10, 1'b1, 8'h2E, 1'b1);

        // R3 24..31 bits
        run_frame("R3", 3, 24, 2'b00, 1'b1, 8'h30, 1'b1);
        run_frame("R3", 3, 31, 2'b01, 1'b0, 8'h34, 1'b1);
        run_frame("R3", 3, 28, 2'b11, 1'b1, 8'h38, 1'b1);

        // R4 32..39 bits, mode dependent
        run_frame("R4", 4, 32, 2'b00, 1'b0, 8'h40, 1'b1);
        run_frame("R4", 4, 39, 2'b01, 1'b1, 8'h48, 1'b1);
        run_frame("R4", 4, 32, 2'b10, 1'b0, 8'h50, 1'b1);
        run_frame("R4", 4, 39, 2'b11, 1'b1, 8'h58, 1'b1);

        // R5 long frames, through the streaming hand-over
        run_frame("R5", 5, 40, 2'b11, 1'b0, 8'h60, 1'b1);
        run_frame("R5", 6, 48, 2'b10, 1'b1, 8'h68, 1'b1);
        run_frame("R5", 20, 165, 2'b11, 1'b0, 8'h80, 1'b1);

        // R9 short class but no byte delivered
        run_frame("R9", 0, 12, 2'b00, 1'b0, 8'hA0, 1'b1);
        run_frame("R9", 0, 30, 2'b11, 1'b0, 8'hA4, 1'b1);

        // R8 interrupt gating, R10 independent clears
        shrt_ie = 1'b0;
        run_frame("R8", 3, 26, 2'b10, 1'b0, 8'hB0, 1'b0);
        @(posedge clk); #1;
        shrt_ie = 1'b1;
        @(negedge clk);
        check("R8", int'(irq), 1, "irq after enable");
        @(posedge clk); #1;
        clr_shrt = 1'b1;
        @(posedge clk); #1;
        clr_shrt = 1'b0;
        @(negedge clk);
        check("R10", int'(shrt_flag), 0, "shrt_flag after clr_shrt");
        check("R10", int'(eom_flag), 1, "eom_flag after clr_shrt");
        check("R8", int'(irq), 0, "irq after clr_shrt");
        @(posedge clk); #1;
        clr_eom = 1'b1;
        @(posedge clk); #1;
        clr_eom = 1'b0;
        @(negedge clk);
        check("R10", int'(eom_flag), 0, "eom_flag after clr_eom");

        // R12 back-to-back frames still separated
        run_frame("R12", 2, 20, 2'b01, 1'b0, 8'hC0, 1'b1);
        run_frame("R12", 7, 60, 2'b00, 1'b1, 8'hD0, 1'b1);

        repeat (4) @(posedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule